// File: doc/BRIEF.md
# JTAG Nibble-Command Engine

This block turns a byte stream into activity on a JTAG port. Each accepted byte carries two 4-bit codes, and the engine runs them in turn. A code can do nothing, or it can arm a one-nibble escape that loads the next nibble into a 4-bit sync register. The remaining codes set TMS and TDI, give one TCK pulse and, if asked, compare TDO against an expected bit. A mismatch sets a sticky error flag.

Bytes enter through a valid/ready port. `in_ready` is high only while the engine is idle. A byte is taken on a clock edge where both `in_valid` and `in_ready` are high. From the cycle after that edge, `in_ready` stays low until both codes of the byte have finished. While `in_ready` is low, the sender must hold `in_valid` and `in_data`.

A divider input sets the TCK period. The error flag and the sync value each have a plain clear input, and the last TDO level is brought out. The host side is expected to assemble the bytes and to read the error and sync values.

Top module: `tap_nibble_engine`

## Requirements
- R1: `in_ready` is 1 only when idle. After an edge with `in_valid && in_ready`, it is 0 from the next cycle until both codes of that byte have finished. A byte offered while `in_ready` is 0 is taken only once the engine is idle again.
- R2: Bits [3:0] of a byte run first and bits [7:4] run second.
- R3: Code 4'b0000 and codes 4'b001x take one decode cycle each. They produce no TCK pulse and change no output.
- R4: Code 4'b0001 arms an escape. The next nibble is loaded into `sync_o` at the end of its decode cycle and is not run as a code. This holds even when that nibble is the low half of the next byte.
- R5: A code 4'b01xy drives `tms_o`=x (bit 1) and `tdi_o`=y (bit 0) and gives one TCK pulse. It does not touch `err_o`.
- R6: A code 4'b1zxy behaves like R5. It then compares `tdo_i`, sampled on the last clock edge of the TCK high phase, with z (bit 2). A mismatch sets `err_o` from the next cycle.
- R7: `err_o` stays set until a clock edge with `clr_err` high clears it. On that edge the clear wins over a new mismatch.
- R8: A clock edge with `clr_sync` high sets `sync_o` to 0. The clear wins over an escape load on the same edge.
- R9: Timing of a pulsing code: one decode cycle with TCK high. TMS and TDI take their new values at the end of this cycle. Then come a setup phase with TCK high, a low phase and a high phase, each `tck_div`+1 cycles long. `tck_div` is captured at the end of the decode cycle.
- R10: After reset, `tck_o`, `tms_o` and `tdi_o` are 1, `err_o` is 0, `sync_o` is 0 and `in_ready` is 1.
- R11: `tdo_o` equals `tdo_i` as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Engine idle, byte will be taken |
| in_data | input | 8 | Two codes, low nibble first |
| tck_div | input | DIV_W | Extra cycles per TCK phase |
| clr_err | input | 1 | Clear the error flag |
| clr_sync | input | 1 | Clear the sync value |
| tdo_i | input | 1 | TDO from the target |
| tck_o | output | 1 | TCK to the target |
| tms_o | output | 1 | TMS to the target |
| tdi_o | output | 1 | TDI to the target |
| tdo_o | output | 1 | Registered TDO level |
| err_o | output | 1 | Sticky TDO mismatch flag |
| sync_o | output | 4 | Sync value |

## Verification
The engine is driven with several kinds of byte:
- All-NOP and reserved-code bytes, which must show no TCK edge.
- Bytes whose two shift codes use different TMS/TDI pairs, so that swapping the nibble order shows up.
- Check codes with both a matching and a mismatching expected bit, which separate the compare from the sticky set and the clear.
- Escapes inside one byte and across a byte boundary, including an escaped nibble that would fail a check if it were run.

Back-to-back bytes with `in_valid` held high check back-pressure. Nonzero divider values, and a divider change in the middle of a pulse, check the phase lengths and the capture of the divider.

// File: rtl/tapnib_pkg.sv
package tapnib_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int SYNC_W = NIB_W;

  typedef enum logic [1:0] {
    KIND_IDLE  = 2'd0,
    KIND_ESC   = 2'd1,
    KIND_PULSE = 2'd2
  } nib_kind_e;

  typedef struct packed {
    nib_kind_e kind;
    logic      check;
    logic      expect_tdo;
    logic      tms;
    logic      tdi;
  } nib_op_t;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_LOW   = 2'd1,
    PH_HIGH  = 2'd2
  } tck_phase_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_PULSE  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/tapnib_decode.sv
module tapnib_decode
  import tapnib_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  input  logic             esc_pend,
  output nib_op_t          op,
  output logic             load_sync
);
  always_comb begin
    op        = '0;
    op.kind   = KIND_IDLE;
    load_sync = 1'b0;
    if (esc_pend) begin
      load_sync = 1'b1;
    end else if (nib == 4'b0001) begin
      op.kind = KIND_ESC;
    end else if (nib[3]) begin
      op.kind       = KIND_PULSE;
      op.check      = 1'b1;
      op.expect_tdo = nib[2];
      op.tms        = nib[1];
      op.tdi        = nib[0];
    end else if (nib[3:2] == 2'b01) begin
      op.kind = KIND_PULSE;
      op.tms  = nib[1];
      op.tdi  = nib[0];
    end
  end
endmodule

// File: rtl/tapnib_tck_gen.sv
module tapnib_tck_gen
  import tapnib_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div_in,
  output logic             tck,
  output logic             last
);
  tck_phase_e       phase;
  logic             busy;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;
  logic             phase_end;

  assign phase_end = (cnt == div_q);
  assign last      = busy && (phase == PH_HIGH) && phase_end;
  assign tck       = !(busy && (phase == PH_LOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= PH_SETUP;
      cnt   <= '0;
      div_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      phase <= PH_SETUP;
      cnt   <= '0;
      div_q <= div_in;
    end else if (busy) begin
      if (phase_end) begin
        cnt <= '0;
        case (phase)
          PH_SETUP: phase <= PH_LOW;
          PH_LOW:   phase <= PH_HIGH;
          default: begin
            phase <= PH_SETUP;
            busy  <= 1'b0;
          end
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tapnib_status.sv
module tapnib_status
  import tapnib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_err,
  input  logic              clr_sync,
  input  logic              set_err,
  input  logic              load_sync,
  input  logic [SYNC_W-1:0] sync_val,
  output logic              err,
  output logic [SYNC_W-1:0] sync
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err  <= 1'b0;
      sync <= '0;
    end else begin
      if (clr_err)      err <= 1'b0;
      else if (set_err) err <= 1'b1;
      if (clr_sync)       sync <= '0;
      else if (load_sync) sync <= sync_val;
    end
  end
endmodule

// File: rtl/tap_nibble_engine.sv
module tap_nibble_engine
  import tapnib_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [DIV_W-1:0]  tck_div,
  input  logic              clr_err,
  input  logic              clr_sync,
  input  logic              tdo_i,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              tdo_o,
  output logic              err_o,
  output logic [SYNC_W-1:0] sync_o
);
  eng_state_e        state;
  logic [BYTE_W-1:0] byte_q;
  logic              half_q;
  logic              esc_q;
  logic              tms_q, tdi_q, chk_q, exp_q, tdo_q;
  logic [NIB_W-1:0]  cur_nib;
  nib_op_t           op;
  logic              load_sync;
  logic              gen_start, gen_last, nib_done, set_err, accept;

  assign cur_nib   = byte_q[{half_q, 2'b00} +: NIB_W];
  assign in_ready  = (state == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign gen_start = (state == ST_DECODE) && (op.kind == KIND_PULSE);
  assign nib_done  = ((state == ST_DECODE) && (op.kind != KIND_PULSE)) ||
                     ((state == ST_PULSE) && gen_last);
  assign set_err   = (state == ST_PULSE) && gen_last && chk_q && (tdo_i != exp_q);

  tapnib_decode u_dec (
    .nib       (cur_nib),
    .esc_pend  (esc_q),
    .op        (op),
    .load_sync (load_sync)
  );

  tapnib_tck_gen #(.DIV_W(DIV_W)) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (gen_start),
    .div_in (tck_div),
    .tck    (tck_o),
    .last   (gen_last)
  );

  tapnib_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_err   (clr_err),
    .clr_sync  (clr_sync),
    .set_err   (set_err),
    .load_sync ((state == ST_DECODE) && load_sync),
    .sync_val  (cur_nib),
    .err       (err_o),
    .sync      (sync_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      byte_q <= '0;
      half_q <= 1'b0;
      esc_q  <= 1'b0;
      tms_q  <= 1'b1;
      tdi_q  <= 1'b1;
      chk_q  <= 1'b0;
      exp_q  <= 1'b0;
      tdo_q  <= 1'b1;
    end else begin
      tdo_q <= tdo_i;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            byte_q <= in_data;
            half_q <= 1'b0;
            state  <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (load_sync)                esc_q <= 1'b0;
          else if (op.kind == KIND_ESC) esc_q <= 1'b1;
          if (op.kind == KIND_PULSE) begin
            tms_q <= op.tms;
            tdi_q <= op.tdi;
            chk_q <= op.check;
            exp_q <= op.expect_tdo;
            state <= ST_PULSE;
          end
        end
        default: ;
      endcase
      if (nib_done) begin
        if (!half_q) begin
          half_q <= 1'b1;
          state  <= ST_DECODE;
        end else begin
          state <= ST_IDLE;
        end
      end
    end
  end

  assign tms_o = tms_q;
  assign tdi_o = tdi_q;
  assign tdo_o = tdo_q;
endmodule

// File: rtl/tapnib_checker.sv
module tapnib_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       clr_err,
  input logic       clr_sync,
  input logic       tdo_i,
  input logic       tck_o,
  input logic       tms_o,
  input logic       tdi_o,
  input logic       tdo_o,
  input logic       err_o,
  input logic [3:0] sync_o
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1: a taken byte makes the engine busy on the next cycle
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R10: the idle port keeps TCK high
  a_r10_idle_tck_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tck_o);

  // R7: the error flag holds until it is cleared
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !clr_err |=> err_o);

  // R7: the clear wins
  a_r7_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !err_o);

  // R8: the sync clear wins
  a_r8_sync_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sync |=> (sync_o == 4'd0));

  // R9: TMS and TDI do not move while TCK is low
  a_r9_lines_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    !tck_o |-> ($stable(tms_o) && $stable(tdi_o)));

  // R11: the TDO output lags the input by one edge
  a_r11_tdo_delay: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (tdo_o == $past(tdo_i)));
endmodule

bind tap_nibble_engine tapnib_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .clr_err  (clr_err),
  .clr_sync (clr_sync),
  .tdo_i    (tdo_i),
  .tck_o    (tck_o),
  .tms_o    (tms_o),
  .tdi_o    (tdi_o),
  .tdo_o    (tdo_o),
  .err_o    (err_o),
  .sync_o   (sync_o)
);

// File: tb/tap_nibble_engine_tb.sv
module tap_nibble_engine_tb;
  localparam int  DIV_W = 8;
  localparam time CYC   = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [7:0]       in_data = 8'h00;
  logic [DIV_W-1:0] tck_div = '0;
  logic             clr_err = 1'b0;
  logic             clr_sync = 1'b0;
  logic             tdo = 1'b1;
  logic             tck_o, tms_o, tdi_o, tdo_o, err_o;
  logic [3:0]       sync_o;

  always #(CYC/2) clk = ~clk;

  tap_nibble_engine #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tck_div(tck_div), .clr_err(clr_err), .clr_sync(clr_sync),
    .tdo_i(tdo), .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .tdo_o(tdo_o),
    .err_o(err_o), .sync_o(sync_o)
  );

  typedef struct {
    logic       rdy;
    logic       tck;
    logic       tms;
    logic       tdi;
    logic       err;
    logic [3:0] sync;
  } exp_t;

  exp_t       q[$];
  logic [1:0] fall_log[$];
  int         checks = 0, errors = 0, busy_cnt = 0;
  logic       m_tms = 1'b1, m_tdi = 1'b1, m_err = 1'b0, m_pend = 1'b0;
  logic [3:0] m_sync = 4'd0;
  logic       mon_en = 1'b0, cyc_idle = 1'b0, tdo_seen = 1'b1, prev_tck = 1'b1;
  logic       done = 1'b0;

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic push(logic tckv);
    exp_t e;
    e.rdy = 1'b0; e.tck = tckv; e.tms = m_tms; e.tdi = m_tdi;
    e.err = m_err; e.sync = m_sync;
    q.push_back(e);
  endtask

  task automatic plan_byte(logic [7:0] b);
    int d = int'(tck_div);
    logic [3:0] n;
    for (int h = 0; h < 2; h++) begin
      n = (h == 0) ? b[3:0] : b[7:4];
      push(1'b1);
      if (m_pend) begin
        m_sync = n;
        m_pend = 1'b0;
      end else if (n == 4'h1) begin
        m_pend = 1'b1;
      end else if (n[3] || (n[3:2] == 2'b01)) begin
        m_tms = n[1];
        m_tdi = n[0];
        repeat (d + 1) push(1'b1);
        repeat (d + 1) push(1'b0);
        repeat (d + 1) push(1'b1);
        if (n[3] && (n[2] != tdo)) m_err = 1'b1;
      end
    end
  endtask

  always @(posedge clk) tdo_seen <= tdo;

  always @(negedge clk) begin
    exp_t e;
    if (mon_en) begin
      if (q.size() > 0) begin
        e = q.pop_front();
        cyc_idle = 1'b0;
      end else begin
        e.rdy = 1'b1; e.tck = 1'b1; e.tms = m_tms; e.tdi = m_tdi;
        e.err = m_err; e.sync = m_sync;
        cyc_idle = 1'b1;
      end
      chk("R1", "in_ready", in_ready, e.rdy);
      chk("R9", "tck_o", tck_o, e.tck);
      chk("R5", "tms_o", tms_o, e.tms);
      chk("R5", "tdi_o", tdi_o, e.tdi);
      chk("R6", "err_o", err_o, e.err);
      chk("R4", "sync_o", sync_o, e.sync);
      chk("R11", "tdo_o", tdo_o, tdo_seen);
      if (prev_tck && !tck_o) fall_log.push_back({tms_o, tdi_o});
      prev_tck = tck_o;
      if (!in_ready) busy_cnt++;
    end
  end

  task automatic send(logic [7:0] b);
    @(posedge clk); #2;
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      @(posedge clk);
      if (cyc_idle) break;
    end
    #2;
    plan_byte(b);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    @(posedge clk); #2;
  endtask

  task automatic pulse_clr_err();
    wait_idle();
    clr_err = 1'b1;
    @(posedge clk); #2;
    clr_err = 1'b0;
    m_err = 1'b0;
  endtask

  task automatic pulse_clr_sync();
    wait_idle();
    clr_sync = 1'b1;
    @(posedge clk); #2;
    clr_sync = 1'b0;
    m_sync = 4'd0;
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "reset tck_o", tck_o, 1);
    chk("R10", "reset tms_o", tms_o, 1);
    chk("R10", "reset tdi_o", tdi_o, 1);
    chk("R10", "reset err_o", err_o, 0);
    chk("R10", "reset sync_o", sync_o, 0);
    chk("R10", "reset in_ready", in_ready, 1);
    @(posedge clk); #2;
    rst_n  = 1'b1;
    mon_en = 1'b1;

    // R3: NOP and reserved codes give no pulse
    fall_log.delete();
    send(8'h00);
    send(8'h32);
    wait_idle();
    chk("R3", "tck falls after NOP/reserved", fall_log.size(), 0);

    // R2, R5: low nibble first
    send(8'h56);
    wait_idle();
    chk("R2", "pulse count", fall_log.size(), 2);
    if (fall_log.size() == 2) begin
      chk("R2", "first pulse tms/tdi", fall_log[0], 2'b10);
      chk("R2", "second pulse tms/tdi", fall_log[1], 2'b01);
    end

    // R6: matching and mismatching checks
    send(8'hCC);
    wait_idle();
    chk("R6", "err after matching checks", err_o, 0);
    send(8'h8C);
    wait_idle();
    chk("R6", "err after mismatch", err_o, 1);
    send(8'hF5);
    wait_idle();
    chk("R7", "err held over later bytes", err_o, 1);
    pulse_clr_err();
    chk("R7", "err after clear", err_o, 0);

    // R4: escapes inside a byte and across bytes, back-to-back for R1
    send(8'hA1);
    wait_idle();
    chk("R4", "sync after in-byte escape", sync_o, 10);
    send(8'h10);
    send(8'h05);
    wait_idle();
    chk("R4", "sync after cross-byte escape", sync_o, 5);
    fall_log.delete();
    send(8'h81);
    wait_idle();
    chk("R4", "escaped nibble not run (err)", err_o, 0);
    chk("R4", "escaped nibble not run (pulses)", fall_log.size(), 0);
    chk("R4", "escaped nibble loaded", sync_o, 8);
    pulse_clr_sync();
    chk("R8", "sync after clear", sync_o, 0);

    // R9: phase lengths and divider capture
    tck_div = 8'd3;
    busy_cnt = 0;
    send(8'h77);
    wait_idle();
    chk("R9", "busy cycles with divider 3", busy_cnt, 26);
    tck_div = 8'd2;
    send(8'h07);
    @(posedge clk); #2;
    tck_div = 8'd5;
    wait_idle();
    tck_div = 8'd0;

    // R11: TDO level brought out
    tdo = 1'b0;
    @(posedge clk); #2;
    chk("R11", "tdo_o follows tdo_i", tdo_o, 0);
    send(8'h0D);
    wait_idle();
    chk("R6", "err after mismatch with low TDO", err_o, 1);

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule